// File: doc/BRIEF.md
# Table-Driven IQ Sample Frame Packer

This block builds the 32-bit timeslot words of a basic frame out of IQ samples taken from several antenna-carrier channels. A programmable mapping table decides what goes where. Each timeslot owns a fixed group of table entries, called lanes. Every enabled lane names a source channel, a starting bit inside the 32-bit word and a sample width. For each lane the block pops one sample from that channel, trims the sample to the programmed width and places it at the programmed offset. Each sample is its own container, so several lanes or timeslots in a frame may draw from the same channel. Bits that no enabled lane claims stay zero as reserved bits.

Software programs the table one entry at a time through a small indirect register window. An index register selects an entry. A transmit entry register and a receive entry register then read or write the selected entry for each direction. Only the transmit table drives packing; the receive table is held for a separate unpacking block. An enabled entry whose sample would run past bit 31 is refused and a sticky error bit is raised. Because no sample can leave its word, no sample can cross a frame boundary. The table should be set up before `run` is raised. Words built while an entry is being rewritten may carry mixed contents.

A controller with three states sequences the work:
- IDLE: waits for `run`. IDLE→GATHER when `run` is high, starting at timeslot 0, lane 0.
- GATHER: evaluates one lane per cycle and ORs its bits into an accumulator. GATHER→GATHER while lanes remain. GATHER→EMIT after the last lane.
- EMIT: presents the finished word for one cycle. EMIT→GATHER moves to the next timeslot, wrapping at the end of the frame, while `run` is high. EMIT→IDLE when `run` is low.

Top module: `iq_frame_packer`

## Requirements
- R1: After reset `out_valid`, `ch_ready`, `ch_underflow` and `cfg_err` are low, and every entry of both tables reads as zero (disabled).
- R2: `cfg_addr` selects a register: 0 is the index, 1 is the transmit entry at the index, 2 is the receive entry at the index, and 3 is status with `cfg_err` in bit 0. An entry word has enable in bit 0, channel in bits 7:4, position in bits 12:8 and width in bits 21:16. All other bits read as zero. The two tables are stored separately.
- R3: An enabled entry write is refused if width is 0, position+width exceeds 32, or channel ≥ NUM_CH. A refused write leaves the stored entry unchanged and sets the sticky `cfg_err`. Only a write of 1 to bit 0 of status clears `cfg_err`.
- R4: An enabled lane whose channel is valid places the low `width` bits of its formatted sample at word bits [position+width-1 : position]. Bits of overlapping lanes are ORed.
- R5: A disabled lane pops nothing, raises no underflow and contributes no bits. Word bits covered by no enabled lane are zero.
- R6: A channel sample is I in bits 31:16 and Q in bits 15:0. With `fmt16`=1 the formatted sample is the 32-bit word unchanged. With `fmt16`=0 it is {2'b00, I[14:0], Q[14:0]}.
- R7: `ch_ready` pulses for one cycle per enabled lane whose channel is valid. It is never high for a channel that is not valid, and at most one channel is popped per cycle. A channel used by k such lanes in a frame is popped k times.
- R8: An enabled lane whose channel is not valid contributes zeros and pulses `ch_underflow` for that channel. That channel is not popped.
- R9: Words appear in timeslot order 0..NUM_SLOTS-1, then wrap to 0. Consecutive words are LANES+1 cycles apart. `out_frame_start` is high exactly with the slot-0 word.
- R10: If `run` is low when a word is emitted, the packer goes idle and emits nothing more. The next `run` starts again at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables word production |
| fmt16 | input | 1 | 1: 16-bit samples, 0: 15-bit samples |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| cfg_err | output | 1 | Sticky refused-entry flag |
| ch_valid | input | NUM_CH | Per-channel sample available |
| ch_data | input | 32*NUM_CH | Per-channel sample, channel c in bits 32c+31:32c |
| ch_ready | output | NUM_CH | Per-channel pop pulse |
| ch_underflow | output | NUM_CH | Per-channel missing-sample pulse |
| out_valid | output | 1 | Word valid |
| out_data | output | 32 | Packed timeslot word |
| out_slot | output | log2(NUM_SLOTS) | Timeslot index of the word |
| out_frame_start | output | 1 | First word of a frame |

## Verification
The hardest case to reach from the ports is a frame where lanes overlap in channel use while some channels are starved. In that case the pop counts, the underflow counts and the zero-filled bit ranges all have to agree at once. The stimulus reaches it by filling the whole table with random but legal entries in every frame, drawing a random valid mask and sample format, and then tallying pops and underflows per channel. Directed frames add an all-disabled table, one channel repeated in every lane, full-width and boundary-hugging entries, and each kind of refused write.

// File: rtl/iqp_pkg.sv
package iqp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GATHER,
        ST_EMIT
    } pack_state_t;

    typedef struct packed {
        logic       en;
        logic [3:0] ch;
        logic [4:0] pos;
        logic [5:0] wid;
    } map_entry_t;

    localparam logic [1:0] REG_INDEX  = 2'd0;
    localparam logic [1:0] REG_TX     = 2'd1;
    localparam logic [1:0] REG_RX     = 2'd2;
    localparam logic [1:0] REG_STATUS = 2'd3;

    function automatic map_entry_t word_to_entry(input logic [31:0] w);
        map_entry_t e;
        e.en  = w[0];
        e.ch  = w[7:4];
        e.pos = w[12:8];
        e.wid = w[21:16];
        return e;
    endfunction

    function automatic logic [31:0] entry_to_word(input map_entry_t e);
        return {10'd0, e.wid, 3'd0, e.pos, e.ch, 3'd0, e.en};
    endfunction

endpackage

// File: rtl/iqp_map_table.sv
module iqp_map_table
    import iqp_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_CH      = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_wr,
    input  logic [1:0]                     cfg_addr,
    input  logic [31:0]                    cfg_wdata,
    output logic [31:0]                    cfg_rdata,
    output logic                           cfg_err,
    input  logic [$clog2(NUM_ENTRIES)-1:0] lk_idx,
    output map_entry_t                     lk_entry
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam logic [3:0] CH_MAX = 4'(NUM_CH - 1);

    map_entry_t       tx_q [NUM_ENTRIES];
    map_entry_t       rx_q [NUM_ENTRIES];
    logic [IDX_W-1:0] idx_q;
    logic             err_q;
    map_entry_t       wr_e;
    logic             wr_bad;
    logic             unused_wdata;

    assign wr_e   = word_to_entry(cfg_wdata);
    assign wr_bad = wr_e.en && ((wr_e.wid == 6'd0) ||
                                ((7'(wr_e.pos) + 7'(wr_e.wid)) > 7'd32) ||
                                (wr_e.ch > CH_MAX));
    assign unused_wdata = ^{cfg_wdata[31:22], cfg_wdata[15:13], cfg_wdata[3:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            err_q <= 1'b0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                tx_q[i] <= '0;
                rx_q[i] <= '0;
            end
        end else if (cfg_wr) begin
            unique case (cfg_addr)
                REG_INDEX: idx_q <= cfg_wdata[IDX_W-1:0];
                REG_TX: begin
                    if (wr_bad) err_q <= 1'b1;
                    else        tx_q[idx_q] <= wr_e;
                end
                REG_RX: begin
                    if (wr_bad) err_q <= 1'b1;
                    else        rx_q[idx_q] <= wr_e;
                end
                REG_STATUS: if (cfg_wdata[0]) err_q <= 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (cfg_addr)
            REG_INDEX:  cfg_rdata = 32'(idx_q);
            REG_TX:     cfg_rdata = entry_to_word(tx_q[idx_q]);
            REG_RX:     cfg_rdata = entry_to_word(rx_q[idx_q]);
            REG_STATUS: cfg_rdata = {31'd0, err_q};
            default:    cfg_rdata = '0;
        endcase
    end

    assign cfg_err  = err_q;
    assign lk_entry = tx_q[lk_idx];

endmodule

// File: rtl/iqp_lane_place.sv
module iqp_lane_place
    import iqp_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                  active,
    input  map_entry_t            entry,
    input  logic                  fmt16,
    input  logic [NUM_CH*32-1:0]  ch_data,
    input  logic [NUM_CH-1:0]     ch_valid,
    output logic [31:0]           contrib,
    output logic [NUM_CH-1:0]     pop,
    output logic [NUM_CH-1:0]     under
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [CH_W-1:0] sel;
    logic [31:0]     raw;
    logic [31:0]     sample;
    logic [32:0]     wide_mask;
    logic            unused_bits;

    assign sel         = entry.ch[CH_W-1:0];
    assign raw         = ch_data[32*int'(sel) +: 32];
    assign sample      = fmt16 ? raw : {2'b00, raw[30:16], raw[14:0]};
    assign wide_mask   = (33'd1 << entry.wid) - 33'd1;
    assign unused_bits = ^{entry.ch, wide_mask[32]};

    always_comb begin
        contrib = '0;
        pop     = '0;
        under   = '0;
        if (active && entry.en) begin
            if (ch_valid[sel]) begin
                pop[sel] = 1'b1;
                contrib  = (sample & wide_mask[31:0]) << entry.pos;
            end else begin
                under[sel] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/iq_frame_packer.sv
module iq_frame_packer
    import iqp_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_SLOTS = 4,
    parameter int LANES     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run,
    input  logic                          fmt16,
    input  logic                          cfg_wr,
    input  logic [1:0]                    cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    output logic [31:0]                   cfg_rdata,
    output logic                          cfg_err,
    input  logic [NUM_CH-1:0]             ch_valid,
    input  logic [NUM_CH*32-1:0]          ch_data,
    output logic [NUM_CH-1:0]             ch_ready,
    output logic [NUM_CH-1:0]             ch_underflow,
    output logic                          out_valid,
    output logic [31:0]                   out_data,
    output logic [$clog2(NUM_SLOTS)-1:0]  out_slot,
    output logic                          out_frame_start
);
    localparam int NUM_ENTRIES = NUM_SLOTS * LANES;
    localparam int IDX_W       = $clog2(NUM_ENTRIES);
    localparam int SLOT_W      = $clog2(NUM_SLOTS);
    localparam int LANE_W      = $clog2(LANES);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

    pack_state_t       state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [LANE_W-1:0] lane_q;
    logic [31:0]       acc_q;
    logic [IDX_W-1:0]  lk_idx;
    map_entry_t        lk_entry;
    logic [31:0]       contrib;
    logic              gathering;

    assign lk_idx = IDX_W'(int'(slot_q) * LANES + int'(lane_q));

    iqp_map_table #(.NUM_ENTRIES(NUM_ENTRIES), .NUM_CH(NUM_CH)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cfg_err   (cfg_err),
        .lk_idx    (lk_idx),
        .lk_entry  (lk_entry)
    );

    iqp_lane_place #(.NUM_CH(NUM_CH)) u_place (
        .active   (gathering),
        .entry    (lk_entry),
        .fmt16    (fmt16),
        .ch_data  (ch_data),
        .ch_valid (ch_valid),
        .contrib  (contrib),
        .pop      (ch_ready),
        .under    (ch_underflow)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (run) state_d = ST_GATHER;
            ST_GATHER: if (lane_q == LANE_LAST) state_d = ST_EMIT;
            ST_EMIT:   state_d = run ? ST_GATHER : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            lane_q <= '0;
            acc_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    slot_q <= '0;
                    lane_q <= '0;
                    acc_q  <= '0;
                end
                ST_GATHER: begin
                    acc_q  <= acc_q | contrib;
                    lane_q <= (lane_q == LANE_LAST) ? '0 : lane_q + 1'b1;
                end
                ST_EMIT: begin
                    acc_q  <= '0;
                    slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        gathering       = (state_q == ST_GATHER);
        out_valid       = (state_q == ST_EMIT);
        out_data        = out_valid ? acc_q : '0;
        out_slot        = slot_q;
        out_frame_start = out_valid && (slot_q == '0);
    end

endmodule

// File: rtl/iqp_checker.sv
module iqp_checker #(
    parameter int NUM_CH    = 4,
    parameter int NUM_SLOTS = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cfg_wr,
    input logic [1:0]                   cfg_addr,
    input logic [31:0]                  cfg_wdata,
    input logic                         cfg_err,
    input logic [NUM_CH-1:0]            ch_valid,
    input logic [NUM_CH-1:0]            ch_ready,
    input logic [NUM_CH-1:0]            ch_underflow,
    input logic                         out_valid,
    input logic [$clog2(NUM_SLOTS)-1:0] out_slot,
    input logic                         out_frame_start
);
    p_ready_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ready & ~ch_valid) == '0);

    p_single_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_ready));

    p_under_not_popped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ready & ch_underflow) == '0);

    p_under_only_idle_chan_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_underflow & ch_valid) == '0);

    p_word_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_frame_start_slot0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_frame_start |-> (out_valid && out_slot == '0));

    p_no_work_while_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ch_ready == '0 && ch_underflow == '0));

    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !(cfg_wr && cfg_addr == 2'd3 && cfg_wdata[0])) |=> cfg_err);

endmodule

bind iq_frame_packer iqp_checker #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_wr          (cfg_wr),
    .cfg_addr        (cfg_addr),
    .cfg_wdata       (cfg_wdata),
    .cfg_err         (cfg_err),
    .ch_valid        (ch_valid),
    .ch_ready        (ch_ready),
    .ch_underflow    (ch_underflow),
    .out_valid       (out_valid),
    .out_slot        (out_slot),
    .out_frame_start (out_frame_start)
);

// File: tb/iq_frame_packer_test.sv
module iq_frame_packer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 4;
    localparam int NSL   = 4;
    localparam int NLN   = 2;
    localparam int NENT  = NSL * NLN;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run = 1'b0;
    logic             fmt16 = 1'b1;
    logic             cfg_wr = 1'b0;
    logic [1:0]       cfg_addr = 2'd0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;
    logic             cfg_err;
    logic [NCH-1:0]   ch_valid = '0;
    logic [NCH*32-1:0] ch_data;
    logic [NCH-1:0]   ch_ready;
    logic [NCH-1:0]   ch_underflow;
    logic             out_valid;
    logic [31:0]      out_data;
    logic [1:0]       out_slot;
    logic             out_frame_start;

    logic [31:0] dat [NCH];
    logic [31:0] tbl [NENT];
    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always_comb for (int c = 0; c < NCH; c++) ch_data[32*c +: 32] = dat[c];

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_frame_packer #(.NUM_CH(NCH), .NUM_SLOTS(NSL), .LANES(NLN)) uut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: got cycle %0d exp below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h exp %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int en, input int ch, input int pos, input int wid);
        return {10'd0, 6'(wid), 3'd0, 5'(pos), 4'(ch), 3'd0, 1'(en)};
    endfunction

    function automatic logic [31:0] exp_word(input int slot);
        logic [31:0] w = '0;
        for (int l = 0; l < NLN; l++) begin
            logic [31:0] e = tbl[slot*NLN + l];
            int ch  = int'(e[7:4]);
            int pos = int'(e[12:8]);
            int wid = int'(e[21:16]);
            if (e[0] && ch < NCH && ch_valid[ch]) begin
                logic [31:0] s = fmt16 ? dat[ch] : {2'b00, dat[ch][30:16], dat[ch][14:0]};
                logic [31:0] m = (wid >= 32) ? 32'hFFFF_FFFF : ((32'd1 << wid) - 32'd1);
                w = w | ((s & m) << pos);
            end
        end
        return w;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic set_entry(input int idx, input logic [31:0] w);
        wr(2'd0, 32'(idx));
        wr(2'd1, w);
        tbl[idx] = w;
    endtask

    // runs one full frame; checks words, order, spacing and pop/underflow tallies
    task automatic run_frame(input string tag);
        int pops [NCH];
        int unds [NCH];
        int epops [NCH];
        int eunds [NCH];
        int k = 0;
        int last = -1;
        int guard = 0;
        for (int c = 0; c < NCH; c++) begin
            pops[c] = 0; unds[c] = 0; epops[c] = 0; eunds[c] = 0;
        end
        for (int i = 0; i < NENT; i++) begin
            int ch = int'(tbl[i][7:4]);
            if (tbl[i][0]) begin
                if (ch_valid[ch]) epops[ch]++;
                else              eunds[ch]++;
            end
        end
        @(negedge clk);
        run = 1'b1;
        while (k < NSL && guard < 100) begin
            @(negedge clk);
            guard++;
            for (int c = 0; c < NCH; c++) begin
                pops[c] += int'(ch_ready[c]);
                unds[c] += int'(ch_underflow[c]);
            end
            if (out_valid) begin
                chk({tag, " R4 R5 R6 word"}, out_data, exp_word(k));
                chk({tag, " R9 slot order"}, 32'(out_slot), 32'(k));
                chk({tag, " R9 frame start"}, 32'(out_frame_start), 32'(k == 0));
                if (last >= 0) chk({tag, " R9 spacing"}, 32'(guard - last), 32'(NLN + 1));
                last = guard;
                k++;
                if (k == NSL) run = 1'b0;
            end
        end
        chk({tag, " R9 all words seen"}, 32'(k), 32'(NSL));
        for (int c = 0; c < NCH; c++) begin
            chk({tag, " R7 pop count"}, 32'(pops[c]), 32'(epops[c]));
            chk({tag, " R8 underflow count"}, 32'(unds[c]), 32'(eunds[c]));
        end
    endtask

    initial begin
        logic [31:0] r;
        int seed;
        int quiet;
        seed = $urandom(32'h5EED_1234);
        for (int c = 0; c < NCH; c++) dat[c] = '0;
        for (int i = 0; i < NENT; i++) tbl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 ready/underflow", 32'({ch_ready, ch_underflow}), 0);
        rd(2'd3, r); chk("R1 status", r, 0);
        for (int i = 0; i < NENT; i++) begin
            wr(2'd0, 32'(i));
            rd(2'd1, r); chk("R1 tx entry zero", r, 0);
            rd(2'd2, r); chk("R1 rx entry zero", r, 0);
        end

        // R2 readback and separate tables
        set_entry(3, enc(1, 2, 7, 9));
        rd(2'd0, r); chk("R2 index", r, 3);
        rd(2'd1, r); chk("R2 tx readback", r, enc(1, 2, 7, 9));
        wr(2'd2, enc(1, 1, 0, 32));
        rd(2'd2, r); chk("R2 rx readback", r, enc(1, 1, 0, 32));
        rd(2'd1, r); chk("R2 tx untouched by rx", r, enc(1, 2, 7, 9));
        wr(2'd1, 32'hFFC0_E00E | enc(1, 3, 16, 16));
        tbl[3] = enc(1, 3, 16, 16);
        rd(2'd1, r); chk("R2 spare bits read zero", r, enc(1, 3, 16, 16));

        // R3 refused writes
        wr(2'd1, enc(1, 0, 4, 0));
        rd(2'd1, r); chk("R3 width0 unchanged", r, enc(1, 3, 16, 16));
        rd(2'd3, r); chk("R3 err set", r, 1);
        wr(2'd3, 32'd0);
        rd(2'd3, r); chk("R3 err sticky on write 0", r, 1);
        wr(2'd3, 32'd1);
        rd(2'd3, r); chk("R3 err cleared", r, 0);
        wr(2'd1, enc(1, 0, 20, 13));
        rd(2'd1, r); chk("R3 overrun unchanged", r, enc(1, 3, 16, 16));
        rd(2'd3, r); chk("R3 overrun err", r, 1);
        wr(2'd3, 32'd1);
        wr(2'd2, enc(1, 5, 0, 8));
        rd(2'd2, r); chk("R3 bad channel rx unchanged", r, enc(1, 1, 0, 32));
        rd(2'd3, r); chk("R3 bad channel err", r, 1);
        wr(2'd3, 32'd1);
        wr(2'd1, enc(0, 0, 31, 63));
        tbl[3] = enc(0, 0, 31, 63);
        rd(2'd3, r); chk("R3 disabled not validated", r, 0);

        // R5 all disabled: zero words, no pops
        for (int i = 0; i < NENT; i++) set_entry(i, 32'd0);
        ch_valid = '1;
        for (int c = 0; c < NCH; c++) dat[c] = $urandom;
        run_frame("disabled R5");

        // R7 same channel in every lane, boundary entries
        for (int i = 0; i < NENT; i++)
            set_entry(i, (i % 2 == 0) ? enc(1, 1, 0, 32) : enc(1, 1, 16, 16));
        fmt16 = 1'b0;
        run_frame("repeat R7");
        fmt16 = 1'b1;
        run_frame("repeat16 R6");

        // R8 starved channels
        ch_valid = 4'b0101;
        for (int i = 0; i < NENT; i++) set_entry(i, enc(1, i % NCH, (i % 2) * 16, 16));
        run_frame("starved R8");

        // R10 stop and idle, restart at slot 0
        quiet = 0;
        repeat (12) begin
            @(negedge clk);
            quiet += int'(out_valid) + int'(|ch_ready) + int'(|ch_underflow);
        end
        chk("R10 idle after stop", 32'(quiet), 0);

        // random frames
        for (int it = 0; it < 40; it++) begin
            for (int i = 0; i < NENT; i++) begin
                int wid = 1 + int'($urandom % 32);
                int pos = int'($urandom % (33 - wid));
                set_entry(i, enc(($urandom % 4) != 0, int'($urandom % NCH), pos, wid));
            end
            for (int c = 0; c < NCH; c++) dat[c] = $urandom;
            ch_valid = 4'($urandom);
            fmt16 = 1'($urandom);
            run_frame("random R4");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule